// File: doc/BRIEF.md
# Serial Receiver with Line Status Reporting

This block turns an asynchronous serial input into data words. It takes the line, a 16x oversample tick and the word length and parity settings that the matching transmitter uses. Each received word goes into a small FIFO together with three error tags: parity, framing and break. The host pops words one at a time. It also reads a line status byte that reports data availability, overrun, the error tags of the word at the head, and a summary bit that stays set while any queued word carries an error.

A line that stays at spacing for a whole frame is reported as a break, not as a framing error, and it enqueues a single zero word. An overrun discards the word that has just arrived and keeps the older words already in the FIFO. When an overrun, parity, framing or break indication newly appears in the status byte, the block sends a two-byte exception report. The modem status byte goes first and the line status byte second.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset, `lsr_o` is 0x00 and `rpt_valid_o` is 0. Status bits 5 and 6 always read 0.
- R2: Words arrive LSB first after a start bit. `wlen_i` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. `data_o` holds the head word right-aligned, with the unused upper bits at 0.
- R3: When `par_en_i` is 1, a parity bit follows the data. With `par_stick_i` at 0, `par_even_i`=1 expects even parity and 0 expects odd parity. With `par_stick_i` at 1, the expected bit is the inverse of `par_even_i`. A mismatch tags the word, and status bit 2 shows that tag while the word is at the head.
- R4: A start bit is confirmed at its middle. A low pulse shorter than half a bit is ignored and enqueues nothing.
- R5: Status bit 0 rises only after the stop bit has been sampled and the word has entered the FIFO. It stays high until the FIFO is empty.
- R6: The FIFO holds DEPTH words (4 by default). A word that completes while the FIFO is full is dropped and sets status bit 1. The stored words and their order are kept.
- R7: A stop bit sampled low in a frame that is not all zero tags the word with a framing error, shown in status bit 3.
- R8: A frame that is low from the start bit through the stop bit enqueues exactly one word of value 0, tagged as a break and shown in status bit 4. Nothing more is enqueued until the line returns high.
- R9: Status bit 7 is 1 while any word in the FIFO carries a parity, framing or break tag. A status read does not clear it.
- R10: A pulse on `stat_rd_i` clears status bit 1. It also hides bits 2 to 4 until the head of the FIFO changes.
- R11: When any of status bits 1 to 4 goes from 0 to 1, `rpt_valid_o` is high for two consecutive cycles. In the first cycle `rpt_first_o` is 1 and `rpt_byte_o` carries `modem_stat_i`. In the second cycle `rpt_byte_o` carries the line status byte from the cycle in which the bit rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | 16x oversample enable |
| wlen_i | input | 2 | Word length code |
| par_en_i | input | 1 | Parity enable |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Fixed parity select |
| modem_stat_i | input | 8 | Modem status byte for the report |
| data_rd_i | input | 1 | Pop the head word |
| stat_rd_i | input | 1 | Status read strobe |
| data_o | output | 8 | Head word |
| lsr_o | output | 8 | Line status byte |
| rpt_valid_o | output | 1 | Report byte valid |
| rpt_first_o | output | 1 | Marks the first report byte |
| rpt_byte_o | output | 8 | Report byte |

## Verification
The assertions assume that `data_rd_i` is pulsed only when status bit 0 is set. They also assume that the line settings stay fixed while a frame is in flight, because the receiver reads them live at every sample point. The stimulus changes the word length and parity settings only while the line is idle. It pops only after checking the status byte, and it holds `modem_stat_i` steady, so every report byte can be predicted exactly. The bench keeps `tick_i` high on every cycle, so one bit lasts 16 clocks. Frames are built bit by bit from the requirement rules, including deliberately wrong parity bits, a low stop bit and a line held low for a whole frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_tag_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_st_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  output logic       wvalid_o,
  output logic [7:0] wdata_o,
  output rx_tag_t    wtag_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_st_e        st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q;
  logic          par_q;
  logic [2:0]    last_idx;
  logic [7:0]    data_al;
  logic          exp_par, is_brk;

  assign last_idx = 3'd4 + {1'b0, wlen_i};
  assign data_al  = sh_q >> (3'd7 - last_idx);
  assign exp_par  = par_stick_i ? ~par_even_i : (^data_al) ^ ~par_even_i;
  assign is_brk   = (data_al == 8'h00) && !(par_en_i && par_q) && !rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      wvalid_o <= 1'b0;
      wdata_o  <= '0;
      wtag_o   <= '0;
    end else begin
      wvalid_o <= 1'b0;
      case (st_q)
        S_IDLE: if (tick_i && !rx_i) begin
          st_q  <= S_START;
          cnt_q <= '0;
        end
        S_START: if (tick_i) begin
          if (cnt_q == MID) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= rx_i ? S_IDLE : S_DATA;  // glitch rejection
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_DATA: if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {rx_i, sh_q[7:1]};
            if (idx_q == last_idx) st_q <= par_en_i ? S_PAR : S_STOP;
            else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_PAR: if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            par_q <= rx_i;
            st_q  <= S_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_STOP: if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_q      <= '0;
            wvalid_o   <= 1'b1;
            wdata_o    <= data_al;
            wtag_o.brk <= is_brk;
            wtag_o.fe  <= !rx_i && !is_brk;
            wtag_o.pe  <= par_en_i && (par_q != exp_par) && !is_brk;
            st_q       <= rx_i ? S_IDLE : S_HOLD;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_HOLD: if (rx_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r8_break_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && wtag_o.brk) |-> (wdata_o == 8'h00));
  a_r8_break_waits_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && wtag_o.brk) |-> (st_q != S_START));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         din_err_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         any_err_o,
  output logic         ovr_o,
  output logic         head_chg_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEPTH-1:0] err_q;
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q, ecnt_q;
  logic             full, push_ok, pop_ok;

  assign full       = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign push_ok    = push_i && (!full || pop_i);
  assign pop_ok     = pop_i && !empty_o;
  assign ovr_o      = push_i && !push_ok;  // newest word dropped
  assign dout_o     = mem_q[rp_q];
  assign any_err_o  = (ecnt_q != '0);
  assign head_chg_o = pop_ok || (push_ok && empty_o);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ecnt_q <= '0;
      err_q  <= '0;
    end else begin
      if (push_ok) begin
        err_q[wp_q] <= din_err_i;
        wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      end
      if (pop_ok) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q  <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      ecnt_q <= ecnt_q + CW'(push_ok && din_err_i) - CW'(pop_ok && err_q[rp_q]);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r6_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> $stable(cnt_q));
  a_r5_no_word_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
  a_r9_err_within_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecnt_q <= cnt_q);
  a_r5_pop_only_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int OSR   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic [7:0] modem_stat_i,
  input  logic       data_rd_i,
  input  logic       stat_rd_i,
  output logic [7:0] data_o,
  output logic [7:0] lsr_o,
  output logic       rpt_valid_o,
  output logic       rpt_first_o,
  output logic [7:0] rpt_byte_o
);
  localparam int W = 8 + $bits(rx_tag_t);

  logic       rx_s1_q, rx_s2_q;
  logic       wvalid;
  logic [7:0] wdata;
  rx_tag_t    wtag, head_tag;
  logic [W-1:0] head;
  logic       empty, any_err, ovr, head_chg;
  logic       oe_q, mask_q, show;
  logic [4:1] lsr_q;
  logic       evt;
  logic [1:0] rpt_st_q;
  logic [7:0] snap_msr_q, snap_lsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {rx_s1_q, rx_s2_q} <= 2'b11;
    else         {rx_s1_q, rx_s2_q} <= {rx_i, rx_s1_q};
  end

  uart_rx_deser #(.OSR(OSR)) u_deser (
    .clk_i, .rst_ni, .rx_i(rx_s2_q), .tick_i, .wlen_i,
    .par_en_i, .par_even_i, .par_stick_i,
    .wvalid_o(wvalid), .wdata_o(wdata), .wtag_o(wtag)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk_i, .rst_ni, .push_i(wvalid), .din_i({wtag, wdata}), .din_err_i(|wtag),
    .pop_i(data_rd_i), .dout_o(head), .empty_o(empty), .any_err_o(any_err),
    .ovr_o(ovr), .head_chg_o(head_chg)
  );

  assign head_tag = rx_tag_t'(head[W-1:8]);
  assign data_o   = head[7:0];
  assign show     = !empty && !mask_q;
  assign lsr_o    = {any_err, 2'b00, head_tag.brk & show, head_tag.fe & show,
                     head_tag.pe & show, oe_q, !empty};
  assign evt      = |(lsr_o[4:1] & ~lsr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q       <= 1'b0;
      mask_q     <= 1'b0;
      lsr_q      <= '0;
      rpt_st_q   <= '0;
      snap_msr_q <= '0;
      snap_lsr_q <= '0;
    end else begin
      if (ovr)            oe_q <= 1'b1;
      else if (stat_rd_i) oe_q <= 1'b0;
      if (head_chg)       mask_q <= 1'b0;
      else if (stat_rd_i) mask_q <= 1'b1;
      lsr_q <= lsr_o[4:1];
      if (evt) begin
        rpt_st_q   <= 2'd1;
        snap_msr_q <= modem_stat_i;
        snap_lsr_q <= lsr_o;
      end else if (rpt_st_q == 2'd1) rpt_st_q <= 2'd2;
      else rpt_st_q <= 2'd0;
    end
  end

  assign rpt_valid_o = (rpt_st_q != 2'd0);
  assign rpt_first_o = (rpt_st_q == 2'd1);
  assign rpt_byte_o  = rpt_first_o ? snap_msr_q : snap_lsr_q;

  a_r11_second_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && rpt_first_o && !evt) |=> (rpt_valid_o && !rpt_first_o));
  a_r10_oe_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ovr) |=> !lsr_o[1]);
  a_r6_oe_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr |=> lsr_o[1]);
  a_r1_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[6:5] == 2'b00);
  a_r9_summary_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[7] |-> lsr_o[0]);
endmodule

// File: tb/uart_rx_lsr_bench.sv
module uart_rx_lsr_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, tick = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic pen = 1'b0, pev = 1'b0, pst = 1'b0;
  logic [7:0] msr = 8'hB1;
  logic drd = 1'b0, srd = 1'b0;
  logic [7:0] data, lsr, rbyte;
  logic rvalid, rfirst;

  int total = 0, bad = 0, rpt_cnt = 0;
  logic [7:0] rec_msr = '0, rec_lsr = '0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rx_lsr u_uart_rx_lsr (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .wlen_i(wlen),
    .par_en_i(pen), .par_even_i(pev), .par_stick_i(pst), .modem_stat_i(msr),
    .data_rd_i(drd), .stat_rd_i(srd), .data_o(data), .lsr_o(lsr),
    .rpt_valid_o(rvalid), .rpt_first_o(rfirst), .rpt_byte_o(rbyte)
  );

  always @(negedge clk) if (rvalid) begin
    if (rfirst) rec_msr <= rbyte;
    else begin rec_lsr <= rbyte; rpt_cnt <= rpt_cnt + 1; end
  end

  typedef struct packed {
    logic [1:0] wl; logic pe; logic ev; logic st; logic badp; logic [7:0] d;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF6},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2B},
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7F},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'h41},
    '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'hC3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic v);
    rx = v;
    idle(16);
  endtask

  task automatic send_head(input logic [7:0] d, input int nb, input bit has_p, input logic pb);
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (has_p) bit_out(pb);
  endtask

  task automatic send_tail(input logic stopv);
    bit_out(stopv);
    rx = 1'b1;
    idle(8);
  endtask

  task automatic send8(input logic [7:0] d);
    send_head(d, 8, 1'b0, 1'b0);
    send_tail(1'b1);
  endtask

  task automatic pulse_srd;
    srd = 1'b1; idle(1); srd = 1'b0; idle(1);
  endtask

  task automatic pulse_drd;
    drd = 1'b1; idle(1); drd = 1'b0; idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rc;
    logic [7:0] msk, exp_lsr;
    logic pb;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 reset lsr", lsr, 8'h00);
    chk("R1 reset report", {7'd0, rvalid}, 8'h00);

    // table walk: framing and parity modes
    for (int k = 0; k < 6; k++) begin
      wlen = VEC[k].wl; pen = VEC[k].pe; pev = VEC[k].ev; pst = VEC[k].st;
      idle(2);
      msk = 8'hFF >> (3 - VEC[k].wl);
      pb  = VEC[k].st ? ~VEC[k].ev : (VEC[k].ev ? ^(VEC[k].d & msk) : ~^(VEC[k].d & msk));
      if (VEC[k].badp) pb = ~pb;
      rc = rpt_cnt;
      send_head(VEC[k].d, 5 + int'(VEC[k].wl), VEC[k].pe, pb);
      chk("R5 ready not before stop", {7'd0, lsr[0]}, 8'h00);
      send_tail(1'b1);
      idle(4);
      exp_lsr = VEC[k].badp ? 8'h85 : 8'h01;
      chk("R2 word data", data, VEC[k].d & msk);
      chk("R3 parity status", lsr, exp_lsr);
      chk("R11 report count", 8'(rpt_cnt - rc), VEC[k].badp ? 8'd1 : 8'd0);
      if (VEC[k].badp) begin
        chk("R11 report msr", rec_msr, 8'hB1);
        chk("R11 report lsr", rec_lsr, 8'h85);
      end
      pulse_srd;
      pulse_drd;
      idle(2);
      chk("R5 ready clears on empty", lsr, 8'h00);
    end

    // R4 glitch
    wlen = 2'd3; pen = 1'b0; pev = 1'b0; pst = 1'b0;
    idle(2);
    rc = rpt_cnt;
    rx = 1'b0; idle(5); rx = 1'b1; idle(400);
    chk("R4 glitch ignored", lsr, 8'h00);

    // R6 overrun
    for (int i = 0; i < 5; i++) send8(8'h10 + 8'(i));
    idle(4);
    chk("R6 overrun status", lsr, 8'h03);
    chk("R11 overrun report count", 8'(rpt_cnt - rc), 8'd1);
    chk("R11 overrun report msr", rec_msr, 8'hB1);
    chk("R11 overrun report lsr", rec_lsr, 8'h03);
    pulse_srd;
    chk("R10 overrun cleared", lsr, 8'h01);
    for (int i = 0; i < 4; i++) begin
      chk("R6 kept words", data, 8'h10 + 8'(i));
      pulse_drd;
    end
    chk("R6 newest dropped", lsr, 8'h00);

    // R7 framing error
    rc = rpt_cnt;
    send_head(8'h55, 8, 1'b0, 1'b0);
    send_tail(1'b0);
    idle(4);
    chk("R7 framing status", lsr, 8'h89);
    chk("R7 framing data", data, 8'h55);
    chk("R11 framing report", rec_lsr, 8'h89);
    pulse_srd;
    chk("R10 tags hidden after read", lsr, 8'h81);
    pulse_drd;
    chk("R7 empty after pop", lsr, 8'h00);

    // R8 break
    rx = 1'b0; idle(16 * 14); rx = 1'b1; idle(20);
    chk("R8 break status", lsr, 8'h91);
    chk("R8 break data", data, 8'h00);
    chk("R11 break report", rec_lsr, 8'h91);
    pulse_srd;
    chk("R9 summary survives read", lsr, 8'h81);
    pulse_drd;
    chk("R8 single break word", lsr, 8'h00);

    // R9 summary with mixed entries
    pen = 1'b1; pev = 1'b1; pst = 1'b0;
    idle(2);
    send_head(8'h33, 8, 1'b1, 1'b1);  // wrong: even parity of 0x33 is 0
    send_tail(1'b1);
    send_head(8'h44, 8, 1'b1, 1'b0);
    send_tail(1'b1);
    idle(4);
    chk("R9 summary set", lsr, 8'h85);
    pulse_drd;
    chk("R9 summary clears", lsr, 8'h01);
    chk("R9 next word", data, 8'h44);
    pulse_drd;
    chk("R9 empty", lsr, 8'h00);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule